// File: doc/BRIEF.md
# Pixel PLL Divider Search Engine

This block takes a requested pixel clock in kHz and finds a set of integer dividers for a pixel PLL whose output comes as close as possible to that request. The PLL output is REF·M/(N·P1·P2), with REF = 96,000 kHz and a composite feedback value M = 5·(M1−2)+(M2−2). The block first picks a pixel multiplier (1 to 4) that lifts the request into the 100–200 MHz band. It then walks through every divider combination, one per clock, and keeps the legal candidate with the smallest error. A short serial division at the end turns the winning ratio into the achieved frequency.

The controller is a state machine with six named states. S_IDLE waits for `start` and captures the target. S_PICK chooses the multiplier and goes to S_SCAN when one fits, or to S_DONE when none does. S_SCAN tests one candidate per cycle. After the last candidate it goes to S_DLOAD if some candidate was legal, and to S_DONE otherwise. S_DLOAD starts the divider. S_DIV waits until the quotient is ready and then goes to S_DONE. S_DONE raises `done` for one cycle and returns to S_IDLE. All comparisons use cross-multiplied integer terms, so the search itself needs no divide.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `done` and `valid` are 0, and `mult`, every divider output and `freq_khz` are 0.
- R2: The multiplier is the smallest k in 1..4 for which target·k lies in [100000, 200000] kHz (inclusive). `mult` carries k as a plain binary number, and target·k is the PLL goal.
- R3: If no k in 1..4 fits, `done` pulses no later than the third cycle after `start` is taken, `valid` is 0, and `mult`, the dividers and `freq_khz` read 0.
- R4: A candidate is legal only if all of the following hold: N in 1..4, M1 in 17..23, M2 in 5..11, P1 in 1..3, M in 104..138, M2 strictly below M1, REF·M/N in [1750000, 3500000] kHz, and REF·M/(N·P1·P2) in [25000, 270000] kHz.
- R5: Among the legal candidates, the reported one has the smallest exact error |REF·M/(N·P1·P2) − goal|. The scan order is N slowest, then M1, then M2, then P1 fastest, each ascending. On equal error the earliest candidate in that order is kept.
- R6: `freq_khz` equals floor(REF·M/(N·P1·P2)) for the reported dividers.
- R7: `done` is high for exactly one cycle. The results stay unchanged after it until the next `start`.
- R8: P2 is fixed, and `p2_div` reads 10 whenever `valid` is 1.
- R9: Candidates are evaluated one per clock, so an in-band request completes within 588 + 40 cycles of `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a search when idle |
| target_khz | input | 18 | Requested pixel clock in kHz |
| done | output | 1 | One-cycle end-of-search pulse |
| valid | output | 1 | Result holds a legal candidate |
| mult | output | 3 | Chosen pixel multiplier |
| n_div | output | 8 | Reference divider N |
| m1_div | output | 8 | Feedback divider M1 |
| m2_div | output | 8 | Feedback divider M2 |
| p1_div | output | 8 | Post divider P1 |
| p2_div | output | 8 | Post divider P2 |
| freq_khz | output | 20 | Achieved PLL output, kHz, rounded down |

## Verification
Targets are swept in coarse steps across 11 MHz to 215 MHz, so every multiplier value is used, and so are both out-of-band regions, below the lowest band and above the highest. Hand-picked points sit on the band edges (25, 100 and 200 MHz), just past them, and where two multipliers meet. These points separate an off-by-one in the band test from a wrong multiplier order. For every target the bench works out the best candidate on its own with exact rational error and first-wins ties. This catches a wrong scan order, a wrong tie rule, or a constraint check that is missing or misplaced, and it also confirms the rounded-down frequency and the single-cycle `done`.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
    localparam int WIDE   = 48;
    localparam int DIVR_W = 8;

    typedef logic [WIDE-1:0]   wide_t;
    typedef logic [DIVR_W-1:0] divr_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_SCAN,
        S_DLOAD,
        S_DIV,
        S_DONE
    } srch_state_t;
endpackage

// File: rtl/pll_mult_pick.sv
module pll_mult_pick
    import pll_srch_pkg::*;
#(
    parameter int TGT_W    = 18,
    parameter int BAND_LO  = 100000,
    parameter int BAND_HI  = 200000,
    parameter int MULT_MAX = 4
) (
    input  logic [TGT_W-1:0] target,
    output logic             hit,
    output logic [2:0]       mult,
    output wide_t            scaled
);
    // Walk from the largest multiplier down so the smallest fitting one wins.
    always_comb begin
        hit    = 1'b0;
        mult   = '0;
        scaled = '0;
        for (int k = MULT_MAX; k >= 1; k--) begin
            wide_t prod;
            prod = wide_t'(target) * wide_t'(k);
            if (prod >= wide_t'(BAND_LO) && prod <= wide_t'(BAND_HI)) begin
                hit    = 1'b1;
                mult   = 3'(k);
                scaled = prod;
            end
        end
    end
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
    import pll_srch_pkg::*;
#(
    parameter int REF_KHZ = 96000,
    parameter int N_MIN   = 1,
    parameter int N_MAX   = 4,
    parameter int M1_MIN  = 17,
    parameter int M1_MAX  = 23,
    parameter int M2_MIN  = 5,
    parameter int M2_MAX  = 11,
    parameter int P1_MIN  = 1,
    parameter int P1_MAX  = 3,
    parameter int P2_VAL  = 10,
    parameter int M_MIN   = 104,
    parameter int M_MAX   = 138,
    parameter int VCO_MIN = 1750000,
    parameter int VCO_MAX = 3500000,
    parameter int F_MIN   = 25000,
    parameter int F_MAX   = 270000
) (
    input  divr_t n,
    input  divr_t m1,
    input  divr_t m2,
    input  divr_t p1,
    input  wide_t goal,
    output logic  ok,
    output wide_t prod,
    output wide_t den,
    output wide_t err_num
);
    wide_t m_val;
    wide_t goal_x;
    logic  rng_ok;

    always_comb begin
        m_val   = wide_t'(5) * (wide_t'(m1) - wide_t'(2)) + (wide_t'(m2) - wide_t'(2));
        prod    = wide_t'(REF_KHZ) * m_val;
        den     = wide_t'(n) * wide_t'(p1) * wide_t'(P2_VAL);
        goal_x  = goal * den;
        rng_ok  = (n  >= divr_t'(N_MIN))  && (n  <= divr_t'(N_MAX))  &&
                  (m1 >= divr_t'(M1_MIN)) && (m1 <= divr_t'(M1_MAX)) &&
                  (m2 >= divr_t'(M2_MIN)) && (m2 <= divr_t'(M2_MAX)) &&
                  (p1 >= divr_t'(P1_MIN)) && (p1 <= divr_t'(P1_MAX));
        ok      = rng_ok &&
                  (m_val >= wide_t'(M_MIN)) && (m_val <= wide_t'(M_MAX)) &&
                  (m2 < m1) &&
                  (prod >= wide_t'(VCO_MIN) * wide_t'(n)) &&
                  (prod <= wide_t'(VCO_MAX) * wide_t'(n)) &&
                  (prod >= wide_t'(F_MIN) * den) &&
                  (prod <= wide_t'(F_MAX) * den);
        err_num = (prod >= goal_x) ? (prod - goal_x) : (goal_x - prod);
    end
endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       trial;
    logic             fits;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        fits  = trial >= {1'b0, divisor};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            cnt_q <= CNT_W'(W);
        end else if (cnt_q != '0) begin
            rem_q <= fits ? W'(trial - {1'b0, divisor}) : W'(trial);
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy     = (cnt_q != '0);
    assign quotient = quo_q;

    a_r6_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_srch_pkg::*;
#(
    parameter int TGT_W    = 18,
    parameter int FREQ_W   = 20,
    parameter int REF_KHZ  = 96000,
    parameter int N_MIN    = 1,
    parameter int N_MAX    = 4,
    parameter int M1_MIN   = 17,
    parameter int M1_MAX   = 23,
    parameter int M2_MIN   = 5,
    parameter int M2_MAX   = 11,
    parameter int P1_MIN   = 1,
    parameter int P1_MAX   = 3,
    parameter int P2_VAL   = 10,
    parameter int M_MIN    = 104,
    parameter int M_MAX    = 138,
    parameter int VCO_MIN  = 1750000,
    parameter int VCO_MAX  = 3500000,
    parameter int F_MIN    = 25000,
    parameter int F_MAX    = 270000,
    parameter int BAND_LO  = 100000,
    parameter int BAND_HI  = 200000,
    parameter int MULT_MAX = 4,
    parameter int QDIV_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TGT_W-1:0]  target_khz,
    output logic              done,
    output logic              valid,
    output logic [2:0]        mult,
    output logic [7:0]        n_div,
    output logic [7:0]        m1_div,
    output logic [7:0]        m2_div,
    output logic [7:0]        p1_div,
    output logic [7:0]        p2_div,
    output logic [FREQ_W-1:0] freq_khz
);
    srch_state_t state_q, state_d;

    logic [TGT_W-1:0] raw_q;
    wide_t            goal_q;
    divr_t            n_q, m1_q, m2_q, p1_q;
    logic             found_q;
    wide_t            best_num, best_den, best_prod;

    logic             pick_hit;
    logic [2:0]       pick_mult;
    wide_t            pick_scaled;
    logic             c_ok;
    wide_t            c_prod, c_den, c_err;
    logic             better, last;
    logic             div_busy;
    logic [QDIV_W-1:0] div_quo;

    pll_mult_pick #(
        .TGT_W(TGT_W), .BAND_LO(BAND_LO), .BAND_HI(BAND_HI), .MULT_MAX(MULT_MAX)
    ) u_pick (
        .target(raw_q), .hit(pick_hit), .mult(pick_mult), .scaled(pick_scaled)
    );

    pll_cand_eval #(
        .REF_KHZ(REF_KHZ), .N_MIN(N_MIN), .N_MAX(N_MAX), .M1_MIN(M1_MIN),
        .M1_MAX(M1_MAX), .M2_MIN(M2_MIN), .M2_MAX(M2_MAX), .P1_MIN(P1_MIN),
        .P1_MAX(P1_MAX), .P2_VAL(P2_VAL), .M_MIN(M_MIN), .M_MAX(M_MAX),
        .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX), .F_MIN(F_MIN), .F_MAX(F_MAX)
    ) u_eval (
        .n(n_q), .m1(m1_q), .m2(m2_q), .p1(p1_q), .goal(goal_q),
        .ok(c_ok), .prod(c_prod), .den(c_den), .err_num(c_err)
    );

    pll_seq_div #(.W(QDIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(state_q == S_DLOAD),
        .dividend(QDIV_W'(best_prod)), .divisor(QDIV_W'(best_den)),
        .busy(div_busy), .quotient(div_quo)
    );

    // Exact comparison of rational errors: c_err/c_den < best_num/best_den.
    always_comb begin
        better = c_ok && (!found_q || (c_err * best_den < best_num * c_den));
        last   = (n_q == divr_t'(N_MAX)) && (m1_q == divr_t'(M1_MAX)) &&
                 (m2_q == divr_t'(M2_MAX)) && (p1_q == divr_t'(P1_MAX));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_PICK;
            S_PICK:  state_d = pick_hit ? S_SCAN : S_DONE;
            S_SCAN:  if (last) state_d = (found_q || better) ? S_DLOAD : S_DONE;
            S_DLOAD: state_d = S_DIV;
            S_DIV:   if (!div_busy) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;  goal_q <= '0;  found_q <= 1'b0;
            n_q <= '0;  m1_q <= '0;  m2_q <= '0;  p1_q <= '0;
            best_num <= '0;  best_den <= '0;  best_prod <= '0;
            valid <= 1'b0;  mult <= '0;  freq_khz <= '0;
            n_div <= '0;  m1_div <= '0;  m2_div <= '0;  p1_div <= '0;  p2_div <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    raw_q <= target_khz;  valid <= 1'b0;  found_q <= 1'b0;
                    mult <= '0;  freq_khz <= '0;
                    n_div <= '0;  m1_div <= '0;  m2_div <= '0;  p1_div <= '0;  p2_div <= '0;
                end
                S_PICK: begin
                    goal_q <= pick_scaled;
                    mult   <= pick_hit ? pick_mult : 3'd0;
                    n_q  <= divr_t'(N_MIN);   m1_q <= divr_t'(M1_MIN);
                    m2_q <= divr_t'(M2_MIN);  p1_q <= divr_t'(P1_MIN);
                end
                S_SCAN: begin
                    if (better) begin
                        found_q  <= 1'b1;
                        best_num <= c_err;  best_den <= c_den;  best_prod <= c_prod;
                        n_div <= n_q;  m1_div <= m1_q;  m2_div <= m2_q;  p1_div <= p1_q;
                    end
                    if (p1_q != divr_t'(P1_MAX)) p1_q <= p1_q + 1'b1;
                    else begin
                        p1_q <= divr_t'(P1_MIN);
                        if (m2_q != divr_t'(M2_MAX)) m2_q <= m2_q + 1'b1;
                        else begin
                            m2_q <= divr_t'(M2_MIN);
                            if (m1_q != divr_t'(M1_MAX)) m1_q <= m1_q + 1'b1;
                            else begin
                                m1_q <= divr_t'(M1_MIN);
                                n_q  <= n_q + 1'b1;
                            end
                        end
                    end
                    if (last && !(found_q || better)) mult <= '0;
                end
                S_DLOAD: ;
                S_DIV: if (!div_busy) begin
                    freq_khz <= FREQ_W'(div_quo);
                    valid    <= 1'b1;
                    p2_div   <= 8'(P2_VAL);
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign done = (state_q == S_DONE);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (m2_div < m1_div));
    a_r4_ranges: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (n_div >= 8'(N_MIN) && n_div <= 8'(N_MAX) &&
                   p1_div >= 8'(P1_MIN) && p1_div <= 8'(P1_MAX)));
    a_r2_band: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (wide_t'(raw_q) * wide_t'(mult) >= wide_t'(BAND_LO) &&
                   wide_t'(raw_q) * wide_t'(mult) <= wide_t'(BAND_HI)));
    a_r8_p2_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (p2_div == 8'(P2_VAL)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start && $past(state_q) == S_IDLE) |-> $stable(freq_khz));
endmodule

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
    localparam int CLK_NS   = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [17:0] target_khz = '0;
    logic        done, valid;
    logic [2:0]  mult;
    logic [7:0]  n_div, m1_div, m2_div, p1_div, p2_div;
    logic [19:0] freq_khz;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_NS/2) clk = ~clk;

    pll_div_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
        .done(done), .valid(valid), .mult(mult), .n_div(n_div),
        .m1_div(m1_div), .m2_div(m2_div), .p1_div(p1_div), .p2_div(p2_div),
        .freq_khz(freq_khz)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, got cycle %0d expected under %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Independent model of R2, R4, R5, R6.
    task automatic model(input longint t, output longint ek, output bit ev,
                         output longint en, output longint em1, output longint em2,
                         output longint ep1, output longint ef);
        longint goal, bn, bd;
        ek = 0; ev = 0; en = 0; em1 = 0; em2 = 0; ep1 = 0; ef = 0; bn = 0; bd = 1;
        for (int k = 4; k >= 1; k--)
            if (t * k >= 100000 && t * k <= 200000) ek = k;
        if (ek == 0) return;
        goal = t * ek;
        for (int n = 1; n <= 4; n++)
            for (int a = 17; a <= 23; a++)
                for (int b = 5; b <= 11; b++)
                    for (int p = 1; p <= 3; p++) begin
                        longint m, pr, d, e;
                        m  = 5 * (a - 2) + (b - 2);
                        pr = 96000 * m;
                        d  = n * p * 10;
                        if (m < 104 || m > 138 || b >= a) continue;
                        if (pr < 1750000 * n || pr > 3500000 * n) continue;
                        if (pr < 25000 * d || pr > 270000 * d) continue;
                        e = (pr > goal * d) ? pr - goal * d : goal * d - pr;
                        if (!ev || e * bd < bn * d) begin
                            ev = 1; bn = e; bd = d;
                            en = n; em1 = a; em2 = b; ep1 = p; ef = pr / d;
                        end
                    end
    endtask

    task automatic run(input int t);
        longint ek, en, em1, em2, ep1, ef;
        bit ev;
        int lat;
        logic [19:0] f_hold;
        model(t, ek, ev, en, em1, em2, ep1, ef);
        @(negedge clk); start = 1'b1; target_khz = 18'(t);
        @(negedge clk); start = 1'b0; target_khz = 18'h3FFFF;
        lat = 1;
        while (!done && lat < 2000) begin @(negedge clk); lat++; end
        chk("R7 done seen", done, 1);
        chk("R2 mult", mult, ek);
        chk("R5 valid", valid, ev);
        if (ek == 0) begin
            chk("R3 latency ok", (lat <= 3), 1);
            chk("R3 freq zero", freq_khz, 0);
            chk("R3 n zero", n_div, 0);
        end else begin
            chk("R9 latency bound", (lat <= 628), 1);
            chk("R5 n", n_div, en);
            chk("R5 m1", m1_div, em1);
            chk("R5 m2", m2_div, em2);
            chk("R5 p1", p1_div, ep1);
            chk("R8 p2", p2_div, 10);
            chk("R6 freq", freq_khz, ef);
            chk("R4 order", (m2_div < m1_div), 1);
        end
        f_hold = freq_khz;
        @(negedge clk);
        chk("R7 done one cycle", done, 0);
        @(negedge clk);
        chk("R7 result held", freq_khz, f_hold);
        chk("R7 valid held", valid, ev);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 valid", valid, 0);
        chk("R1 mult", mult, 0);
        chk("R1 freq", freq_khz, 0);
        chk("R1 dividers", {n_div, m1_div, m2_div, p1_div, p2_div}, 0);
        rst_n = 1'b1;
        run(150000);
        run(100000);
        run(200000);
        run(200001);
        run(99999);
        run(60000);
        run(66667);
        run(40000);
        run(49999);
        run(30000);
        run(25000);
        run(24999);
        run(20000);
        for (int t = 11000; t <= 215000; t += 9973) run(t);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule